// File: doc/BRIEF.md
# Execute-Packet Cross-Path Rule Checker

This block screens one execute packet of a two-sided datapath before it issues. A packet holds up to `NUM_SLOTS` parallel instructions. For each slot the block receives five things: a valid bit, the functional unit kind (L, S, M or D), the side of that unit, a flag that says an operand comes over a cross path with the side that cross path feeds, and the side of the destination register. Side 1 is encoded as 0 and side 2 as 1. Each side has exactly one data cross path, which brings an operand from the opposite register file.

Three rules apply. The destination must sit on the unit's own side. Only L, S and M units may take an operand across. Each side's cross path may serve at most one instruction per packet. The check is registered. One cycle after the packet strobe, the block presents a per-slot violation code, a packet-ok bit, and the index and code of the lowest-numbered slot that broke a rule.

Top module: `xpath_packet_checker`

## Requirements
- R1: `res_valid` is high in exactly the cycle after a cycle with `pkt_strobe` high, and low otherwise.
- R2: A valid slot whose `dest_side` differs from its `unit_side` gets code 01 in `slot_codes[2i+1:2i]`.
- R3: A valid slot with unit kind D (encoding 11; L=00, S=01, M=10) and `xpath_use` set gets code 10. Such a request does not occupy the cross path.
- R4: A valid slot on an L, S or M unit with `xpath_use` set occupies the cross path named by `xpath_side`. Every such slot after the first on the same `xpath_side` gets code 11. The two sides are counted independently.
- R5: Slots with `slot_valid` low get code 00 and do not occupy a cross path, whatever their other fields hold.
- R6: When one slot breaks several rules, its code follows the priority 01 over 10 over 11.
- R7: `viol_slot` is the lowest slot index with a non-zero code, and `viol_code` is that slot's code.
- R8: `pkt_ok` is high exactly when every slot code is 00. A packet with no valid slots gives `pkt_ok` high, `viol_slot` 0 and `viol_code` 00.
- R9: While `rst` is high at a clock edge, `res_valid`, `pkt_ok`, `slot_codes`, `viol_slot` and `viol_code` all become 0.
- R10: In a cycle without `pkt_strobe`, `pkt_ok`, `slot_codes`, `viol_slot` and `viol_code` keep their values, even if the slot inputs change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pkt_strobe | input | 1 | Packet present on the slot inputs this cycle |
| slot_valid | input | NUM_SLOTS | Slot holds an instruction |
| slot_unit | input | 2*NUM_SLOTS | Unit kind per slot: 00 L, 01 S, 10 M, 11 D |
| unit_side | input | NUM_SLOTS | Side of the executing unit (0 = side 1, 1 = side 2) |
| xpath_use | input | NUM_SLOTS | Slot takes an operand over a cross path |
| xpath_side | input | NUM_SLOTS | Side whose cross path the slot uses |
| dest_side | input | NUM_SLOTS | Side of the destination register |
| res_valid | output | 1 | Result registers hold a fresh check |
| pkt_ok | output | 1 | Packet obeys all rules |
| slot_codes | output | 2*NUM_SLOTS | Violation code per slot |
| viol_slot | output | $clog2(NUM_SLOTS) | Index of the first violating slot |
| viol_code | output | 2 | Code of the first violating slot |

## Verification
Assertions check the following on every cycle: the one-cycle result timing, the holding of results between strobes, and the agreement between `pkt_ok`, the slot codes and the reported first violation. They also check that an empty packet is reported ok, that slot 0's destination-side rule is applied, and that each cross path has at most one accepted user. Only the bench's scenarios show the exact code placed in each slot. That covers the per-slot priority when one slot breaks several rules, the non-occupancy by D-unit and empty slots, and the independence of the two sides' cross paths.

// File: rtl/xpc_pkg.sv
package xpc_pkg;
  typedef enum logic [1:0] {
    UNIT_L = 2'b00,
    UNIT_S = 2'b01,
    UNIT_M = 2'b10,
    UNIT_D = 2'b11
  } unit_kind_e;

  typedef enum logic [1:0] {
    VC_NONE        = 2'b00,
    VC_DEST_SIDE   = 2'b01,
    VC_BAD_UNIT    = 2'b10,
    VC_SECOND_PATH = 2'b11
  } viol_code_e;
endpackage

// File: rtl/xpc_slot_rules.sv
module xpc_slot_rules #(
  parameter int NUM_SLOTS = 8
) (
  input  logic [NUM_SLOTS-1:0]   slot_valid,
  input  logic [2*NUM_SLOTS-1:0] slot_unit,
  input  logic [NUM_SLOTS-1:0]   unit_side,
  input  logic [NUM_SLOTS-1:0]   xpath_use,
  input  logic [NUM_SLOTS-1:0]   dest_side,
  output logic [NUM_SLOTS-1:0]   dest_bad,
  output logic [NUM_SLOTS-1:0]   unit_bad,
  output logic [NUM_SLOTS-1:0]   path_req
);
  import xpc_pkg::*;

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
    logic is_d_unit;
    assign is_d_unit   = (slot_unit[2*i +: 2] == UNIT_D);
    assign dest_bad[i] = slot_valid[i] && (dest_side[i] != unit_side[i]);
    assign unit_bad[i] = slot_valid[i] && xpath_use[i] && is_d_unit;
    // only a legal unit's request takes the cross path
    assign path_req[i] = slot_valid[i] && xpath_use[i] && !is_d_unit;
  end
endmodule

// File: rtl/xpc_path_arbiter.sv
module xpc_path_arbiter #(
  parameter int NUM_SLOTS = 8
) (
  input  logic [NUM_SLOTS-1:0] path_req,
  input  logic [NUM_SLOTS-1:0] xpath_side,
  output logic [NUM_SLOTS-1:0] first_use,
  output logic [NUM_SLOTS-1:0] dup_use
);
  logic [1:0] taken;

  always_comb begin
    taken     = 2'b00;
    first_use = '0;
    dup_use   = '0;
    for (int i = 0; i < NUM_SLOTS; i++) begin
      if (path_req[i]) begin
        if (taken[xpath_side[i]]) dup_use[i] = 1'b1;
        else                      first_use[i] = 1'b1;
        taken[xpath_side[i]] = 1'b1;
      end
    end
  end

  // R4: each side grants its cross path to at most one slot
  always_comb begin
    assert_one_grant_side1_R4: assert ($onehot0(first_use & ~xpath_side));
    assert_one_grant_side2_R4: assert ($onehot0(first_use & xpath_side));
  end
endmodule

// File: rtl/xpc_first_pick.sv
module xpc_first_pick #(
  parameter int NUM_SLOTS = 8,
  parameter int IDX_W     = $clog2(NUM_SLOTS)
) (
  input  logic [2*NUM_SLOTS-1:0] codes,
  output logic                   any_viol,
  output logic [IDX_W-1:0]       first_idx,
  output logic [1:0]             first_code
);
  always_comb begin
    any_viol   = 1'b0;
    first_idx  = '0;
    first_code = 2'b00;
    for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
      if (codes[2*i +: 2] != 2'b00) begin
        any_viol   = 1'b1;
        first_idx  = IDX_W'(i);
        first_code = codes[2*i +: 2];
      end
    end
  end
endmodule

// File: rtl/xpath_packet_checker.sv
module xpath_packet_checker #(
  parameter int NUM_SLOTS = 8,
  localparam int IDX_W    = $clog2(NUM_SLOTS),
  localparam int CODE_W   = 2 * NUM_SLOTS
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 pkt_strobe,
  input  logic [NUM_SLOTS-1:0] slot_valid,
  input  logic [CODE_W-1:0]    slot_unit,
  input  logic [NUM_SLOTS-1:0] unit_side,
  input  logic [NUM_SLOTS-1:0] xpath_use,
  input  logic [NUM_SLOTS-1:0] xpath_side,
  input  logic [NUM_SLOTS-1:0] dest_side,
  output logic                 res_valid,
  output logic                 pkt_ok,
  output logic [CODE_W-1:0]    slot_codes,
  output logic [IDX_W-1:0]     viol_slot,
  output logic [1:0]           viol_code
);
  import xpc_pkg::*;

  logic [NUM_SLOTS-1:0] dest_bad, unit_bad, path_req, first_use, dup_use;
  logic [CODE_W-1:0]    codes_next;
  logic                 any_viol;
  logic [IDX_W-1:0]     idx_next;
  logic [1:0]           code_next;

  xpc_slot_rules #(.NUM_SLOTS(NUM_SLOTS)) i_rules (
    .slot_valid(slot_valid), .slot_unit(slot_unit), .unit_side(unit_side),
    .xpath_use(xpath_use), .dest_side(dest_side),
    .dest_bad(dest_bad), .unit_bad(unit_bad), .path_req(path_req)
  );

  xpc_path_arbiter #(.NUM_SLOTS(NUM_SLOTS)) i_arb (
    .path_req(path_req), .xpath_side(xpath_side),
    .first_use(first_use), .dup_use(dup_use)
  );

  // per-slot priority: destination side, then illegal unit, then duplicate path
  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_code
    always_comb begin
      if (dest_bad[i])      codes_next[2*i +: 2] = VC_DEST_SIDE;
      else if (unit_bad[i]) codes_next[2*i +: 2] = VC_BAD_UNIT;
      else if (dup_use[i])  codes_next[2*i +: 2] = VC_SECOND_PATH;
      else                  codes_next[2*i +: 2] = VC_NONE;
    end
  end

  xpc_first_pick #(.NUM_SLOTS(NUM_SLOTS), .IDX_W(IDX_W)) i_pick (
    .codes(codes_next), .any_viol(any_viol),
    .first_idx(idx_next), .first_code(code_next)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid  <= 1'b0;
      pkt_ok     <= 1'b0;
      slot_codes <= '0;
      viol_slot  <= '0;
      viol_code  <= 2'b00;
    end else begin
      res_valid <= pkt_strobe;
      if (pkt_strobe) begin
        pkt_ok     <= !any_viol;
        slot_codes <= codes_next;
        viol_slot  <= idx_next;
        viol_code  <= code_next;
      end
    end
  end

  assert_result_timing_R1: assert property (@(posedge clk) disable iff (rst)
    pkt_strobe |=> res_valid);
  assert_no_spurious_R1: assert property (@(posedge clk) disable iff (rst)
    !pkt_strobe |=> !res_valid);
  assert_slot0_dest_R2: assert property (@(posedge clk) disable iff (rst)
    (pkt_strobe && slot_valid[0] && (dest_side[0] != unit_side[0]))
      |=> (slot_codes[1:0] == VC_DEST_SIDE));
  assert_empty_packet_R8: assert property (@(posedge clk) disable iff (rst)
    (pkt_strobe && slot_valid == '0) |=> (pkt_ok && viol_code == VC_NONE));
  assert_ok_matches_codes_R8: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> (pkt_ok == (slot_codes == '0)));
  assert_first_code_R7: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> (viol_code == slot_codes[2*viol_slot +: 2]));
  assert_hold_results_R10: assert property (@(posedge clk) disable iff (rst)
    !pkt_strobe |=> ($stable(pkt_ok) && $stable(slot_codes) &&
                     $stable(viol_slot) && $stable(viol_code)));
endmodule

// File: tb/test_xpath_packet_checker.sv
module test_xpath_packet_checker;
  localparam int N = 8;

  typedef struct packed {
    logic [7:0]  valid;
    logic [15:0] unit;
    logic [7:0]  uside;
    logic [7:0]  xuse;
    logic [7:0]  xside;
    logic [7:0]  dside;
    logic [15:0] codes;
    logic        ok;
    logic [2:0]  idx;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    // R8: clean packet, all L units on side 1
    '{8'hFF, 16'h0000, 8'h00, 8'h00, 8'h00, 8'h00, 16'h0000, 1'b1, 3'd0},
    // R2: slot 3 writes the other side
    '{8'hFF, 16'h0000, 8'h00, 8'h00, 8'h00, 8'h08, 16'h0040, 1'b0, 3'd3},
    // R3: slot 5 is a D unit asking for a cross path
    '{8'hFF, 16'h0C00, 8'h00, 8'h20, 8'h20, 8'h00, 16'h0800, 1'b0, 3'd5},
    // R4: slots 1 and 6 both use side-1 path
    '{8'hFF, 16'h2008, 8'h00, 8'h42, 8'h00, 8'h00, 16'h3000, 1'b0, 3'd6},
    // R4: one path per side is fine
    '{8'hFF, 16'h5555, 8'h04, 8'h05, 8'h04, 8'h04, 16'h0000, 1'b1, 3'd0},
    // R5: upper slots invalid, hold faults and a second path
    '{8'h0F, 16'h0000, 8'h00, 8'hC2, 8'h00, 8'h10, 16'h0000, 1'b1, 3'd0},
    // R6/R3: priorities, D requests do not occupy the path
    '{8'hFF, 16'h0033, 8'h00, 8'h95, 8'h00, 8'h01, 16'hC021, 1'b0, 3'd0},
    // R8: empty packet with garbage fields
    '{8'h00, 16'hFFFF, 8'h00, 8'hFF, 8'hFF, 8'hFF, 16'h0000, 1'b1, 3'd0},
    // R4/R6: three side-2 users, slot 3 also wrong destination
    '{8'hFF, 16'h0000, 8'h07, 8'h0F, 8'h0F, 8'h0F, 16'h007C, 1'b0, 3'd1}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pkt_strobe = 1'b0;
  logic [N-1:0] slot_valid = '0, unit_side = '0, xpath_use = '0, xpath_side = '0, dest_side = '0;
  logic [2*N-1:0] slot_unit = '0;
  logic res_valid, pkt_ok;
  logic [2*N-1:0] slot_codes;
  logic [2:0] viol_slot;
  logic [1:0] viol_code;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  xpath_packet_checker #(.NUM_SLOTS(N)) i_xpath_packet_checker (
    .clk(clk), .rst(rst), .pkt_strobe(pkt_strobe), .slot_valid(slot_valid),
    .slot_unit(slot_unit), .unit_side(unit_side), .xpath_use(xpath_use),
    .xpath_side(xpath_side), .dest_side(dest_side), .res_valid(res_valid),
    .pkt_ok(pkt_ok), .slot_codes(slot_codes), .viol_slot(viol_slot),
    .viol_code(viol_code)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive(input vec_t v, input logic strobe);
    slot_valid = v.valid; slot_unit = v.unit; unit_side = v.uside;
    xpath_use = v.xuse; xpath_side = v.xside; dest_side = v.dside;
    pkt_strobe = strobe;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9: reset state
    chk("R9 res_valid", 32'(res_valid), 0);
    chk("R9 pkt_ok", 32'(pkt_ok), 0);
    chk("R9 slot_codes", 32'(slot_codes), 0);
    chk("R9 viol", {27'd0, viol_slot, viol_code}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 idle res_valid", 32'(res_valid), 0);

    for (int k = 0; k < NV; k++) begin
      drive(VECS[k], 1'b1);
      @(negedge clk);
      pkt_strobe = 1'b0;
      chk("R1 res_valid", 32'(res_valid), 1);
      chk("R2-R6 slot_codes", 32'(slot_codes), 32'(VECS[k].codes));
      chk("R8 pkt_ok", 32'(pkt_ok), 32'(VECS[k].ok));
      chk("R7 viol_slot", 32'(viol_slot), 32'(VECS[k].idx));
      chk("R7 viol_code", 32'(viol_code), 32'(VECS[k].codes[2*VECS[k].idx +: 2]));
    end

    // R10: last packet results stay while other inputs arrive without strobe
    drive(VECS[0], 1'b0);
    @(negedge clk);
    chk("R1 no strobe res_valid", 32'(res_valid), 0);
    chk("R10 slot_codes held", 32'(slot_codes), 32'(VECS[NV-1].codes));
    chk("R10 pkt_ok held", 32'(pkt_ok), 0);
    chk("R10 viol_slot held", 32'(viol_slot), 1);

    // R1: back-to-back strobes each produce a result
    drive(VECS[1], 1'b1);
    @(negedge clk);
    drive(VECS[2], 1'b1);
    chk("R1 b2b first", 32'(viol_slot), 3);
    @(negedge clk);
    pkt_strobe = 1'b0;
    chk("R1 b2b second valid", 32'(res_valid), 1);
    chk("R7 b2b second slot", 32'(viol_slot), 5);

    // R9: reset clears results mid-run
    rst = 1'b1;
    @(negedge clk);
    chk("R9 reset res_valid", 32'(res_valid), 0);
    chk("R9 reset codes", 32'(slot_codes), 0);
    chk("R9 reset pkt_ok", 32'(pkt_ok), 0);
    rst = 1'b0;
    @(negedge clk);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule